// File: doc/BRIEF.md
# Paper Tape Reader/Punch Controller

This block is the byte-wide control logic for a shared paper tape reader and punch. A host issues one of four operations per cycle: command, data read, data write and status sense. A single direction flag selects whether the reader or the punch owns the shared busy flag and the shared interrupt. When reading, a run flag starts and stops the tape, and a mode flag picks free-running transport or single-stepping. In free-running mode every accepted character requests the next one. In step mode each host data read requests one more character.

The mechanisms are reached through handshake ports. The reader takes a one-cycle request pulse and answers later with a character strobe, a data byte and an end-of-medium flag. The punch takes a one-cycle start pulse with a byte and answers with a done strobe. The controller tracks busy, overrun, character-pending and end-of-tape. It builds a status byte with a derived no-motion bit and a derived exception bit. It drives a level interrupt that stays high until it is acknowledged.

Top module: `ptrp_ctrl`

## Requirements
- R1: After reset the controller is in read direction, stopped, in step mode and disarmed. Busy is set, the interrupt is low, and a status sense with the reader online returns 0x1C.
- R2: The command byte fields are: bit 0 = 1 read / 0 punch; bit 4 = 1 run / 0 stop; bit 2 = 1 slew / 0 step; bits 7:6 = 10 arm, 01 disarm, other values leave the arm state unchanged. Run and slew are written only when bit 0 of the same command is 1.
- R3: The status byte is: bit 7 overrun, bit 4 no-motion, bit 3 busy, bit 2 exception, bit 0 unavailable; all other bits are 0. No-motion is set when the direction is read, run is clear and no reader request is outstanding. Exception is set when overrun or no-motion is set. Unavailable is set when the selected mechanism's online input is low or end-of-tape is set.
- R4: A command that changes the direction clears overrun. If the newly selected mechanism has work outstanding, busy is set and the interrupt is cleared. Otherwise busy is cleared and, if armed, the interrupt is raised.
- R5: A command that takes run from 0 to 1 issues one reader request and clears end-of-tape. A read command with run 0 cancels any outstanding request. A reader strobe that arrives while run is 0 is discarded: the buffer is unchanged and no request is issued.
- R6: A reader strobe accepted in read direction clears busy and raises the interrupt if armed. It sets overrun if the previous character was still pending, then sets pending and stores the byte.
- R7: In slew mode each accepted character without end-of-medium issues exactly one new reader request. In slew mode a host data read issues none.
- R8: A host data read returns the buffered byte one cycle later, clears pending, and sets busy in read direction. When running in step mode it also issues exactly one reader request and clears end-of-tape.
- R9: A reader strobe with end-of-medium set sets end-of-tape and leaves the buffer unchanged. It issues no slew request and otherwise acts as an accepted character.
- R10: A host data write latches the byte onto the punch data output and pulses punch start for one cycle. It sets busy in punch direction. A punch done in punch direction clears busy and raises the interrupt if armed. A punch done in read direction changes neither busy nor the interrupt.
- R11: The interrupt is a level that stays high until the acknowledge input is pulsed. It is never raised while disarmed.
- R12: A command selecting punch direction clears end-of-tape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host operation valid this cycle |
| host_op | input | 2 | 0 command, 1 data read, 2 data write, 3 status sense |
| host_wdata | input | 8 | Command byte or write data |
| host_rvalid | output | 1 | Read data valid (cycle after a data read or status sense) |
| host_rdata | output | 8 | Returned byte or status |
| irq | output | 1 | Level interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| rdr_req | output | 1 | One-cycle request for the next reader character |
| rdr_strobe | input | 1 | Reader character ready |
| rdr_data | input | CHAR_W | Reader character |
| rdr_eom | input | 1 | Reader end of medium, qualifies rdr_strobe |
| rdr_online | input | 1 | Reader online |
| pch_start | output | 1 | One-cycle punch start |
| pch_data | output | CHAR_W | Byte to punch |
| pch_done | input | 1 | Punch finished |
| pch_online | input | 1 | Punch online |

## Verification
The bench builds the block with CHAR_W = 8, so the whole tape character reaches the host data byte and every bit of the returned buffer can be compared. At this width the punch output carries the full written byte, which lets the bench check write data end to end. The reader and punch mechanisms are modelled by the bench itself, with a strobe timing of its own choosing. This gives exact control over overrun, over strobes that arrive while stopped, over end-of-medium, and over direction changes made while the other mechanism still has work outstanding.

// File: rtl/ptrp_pkg.sv
package ptrp_pkg;
  localparam int HOST_W = 8;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_RDATA = 2'd1,
    OP_WDATA = 2'd2,
    OP_SENSE = 2'd3
  } host_op_e;

  // command byte fields
  localparam int CB_DIR  = 0;
  localparam int CB_SLEW = 2;
  localparam int CB_RUN  = 4;
  localparam int CB_ARM  = 6;

  // status byte fields
  localparam int SB_UNAV = 0;
  localparam int SB_EXC  = 2;
  localparam int SB_BUSY = 3;
  localparam int SB_NOMO = 4;
  localparam int SB_OVR  = 7;
endpackage

// File: rtl/ptrp_mode.sv
module ptrp_mode (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic       cmd_dir,
  input  logic       cmd_run,
  input  logic       cmd_slew,
  input  logic [1:0] cmd_arm,
  output logic       dir_rd,
  output logic       run,
  output logic       slew,
  output logic       armed,
  output logic       arm_next,
  output logic       dir_next,
  output logic       dir_chg,
  output logic       run_start,
  output logic       run_stop,
  output logic       punch_cmd
);
  logic dir_q, run_q, slew_q, arm_q;

  always_comb begin
    arm_next = arm_q;
    if (cmd_we) begin
      if (cmd_arm == 2'b10) arm_next = 1'b1;
      else if (cmd_arm == 2'b01) arm_next = 1'b0;
    end
  end

  assign dir_next  = cmd_we ? cmd_dir : dir_q;
  assign dir_chg   = cmd_we && (cmd_dir != dir_q);
  assign run_start = cmd_we && cmd_dir && cmd_run && !run_q;
  assign run_stop  = cmd_we && cmd_dir && !cmd_run;
  assign punch_cmd = cmd_we && !cmd_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b1;
      run_q  <= 1'b0;
      slew_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= arm_next;
      if (cmd_we) dir_q <= cmd_dir;
      if (cmd_we && cmd_dir) begin
        run_q  <= cmd_run;
        slew_q <= cmd_slew;
      end
    end
  end

  assign dir_rd = dir_q;
  assign run    = run_q;
  assign slew   = slew_q;
  assign armed  = arm_q;

  // R2: a punch-direction command leaves run and slew untouched
  a_r2_punch_keeps_run: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !cmd_dir) |=> ($stable(run_q) && $stable(slew_q)));
endmodule

// File: rtl/ptrp_reader.sv
module ptrp_reader #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_rd,
  input  logic              run,
  input  logic              slew,
  input  logic              run_start,
  input  logic              run_stop,
  input  logic              dir_chg,
  input  logic              punch_cmd,
  input  logic              rd_op,
  input  logic              rdr_strobe,
  input  logic [CHAR_W-1:0] rdr_data,
  input  logic              rdr_eom,
  output logic              rdr_req,
  output logic              rdr_active,
  output logic              char_evt,
  output logic              overrun,
  output logic              eot,
  output logic [CHAR_W-1:0] buf_o
);
  logic              accept, req_step, req_slew, req_next;
  logic              req_q, act_q, pend_q, ovr_q, eot_q;
  logic [CHAR_W-1:0] buf_q;

  assign accept   = rdr_strobe && run;
  assign req_step = rd_op && run && !slew;
  assign req_slew = accept && slew && !rdr_eom;
  assign req_next = (run_start || req_step || req_slew) && !run_stop;
  assign char_evt = accept && dir_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      eot_q  <= 1'b0;
      buf_q  <= '0;
    end else begin
      req_q <= req_next;

      if (run_stop)      act_q <= 1'b0;
      else if (req_next) act_q <= 1'b1;
      else if (accept)   act_q <= 1'b0;

      if (accept)     pend_q <= 1'b1;
      else if (rd_op) pend_q <= 1'b0;

      if (dir_chg) ovr_q <= 1'b0;
      else if (char_evt && pend_q && !rd_op) ovr_q <= 1'b1;

      if (accept && rdr_eom) eot_q <= 1'b1;
      else if (run_start || req_step || punch_cmd) eot_q <= 1'b0;

      if (accept && !rdr_eom) buf_q <= rdr_data;
    end
  end

  assign rdr_req    = req_q;
  assign rdr_active = act_q;
  assign overrun    = ovr_q;
  assign eot        = eot_q;
  assign buf_o      = buf_q;

  // R5: a strobe while stopped does not touch the buffer
  a_r5_stopped_discard: assert property (@(posedge clk) disable iff (rst)
    (rdr_strobe && !run) |=> $stable(buf_q));
  // R9: end-of-medium keeps the buffered byte
  a_r9_eom_keeps_buf: assert property (@(posedge clk) disable iff (rst)
    (rdr_strobe && rdr_eom) |=> $stable(buf_q));
  // R4: a direction change clears overrun
  a_r4_dir_clears_ovr: assert property (@(posedge clk) disable iff (rst)
    dir_chg |=> !ovr_q);
  // R5: a stop command leaves no request outstanding
  a_r5_stop_idles: assert property (@(posedge clk) disable iff (rst)
    run_stop |=> (!act_q && !req_q));
endmodule

// File: rtl/ptrp_punch.sv
module ptrp_punch #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_op,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              pch_done,
  output logic              pch_start,
  output logic [CHAR_W-1:0] pch_data,
  output logic              pch_active,
  output logic              done_evt
);
  logic              start_q, act_q;
  logic [CHAR_W-1:0] data_q;

  assign done_evt = pch_done && act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      act_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      start_q <= wr_op;
      if (wr_op) begin
        act_q  <= 1'b1;
        data_q <= wdata;
      end else if (done_evt) begin
        act_q <= 1'b0;
      end
    end
  end

  assign pch_start  = start_q;
  assign pch_data   = data_q;
  assign pch_active = act_q;

  // R10: every host write produces a start pulse
  a_r10_write_starts: assert property (@(posedge clk) disable iff (rst)
    wr_op |=> (start_q && act_q));
endmodule

// File: rtl/ptrp_ctrl.sv
module ptrp_ctrl
  import ptrp_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic [1:0]        host_op,
  input  logic [7:0]        host_wdata,
  output logic              host_rvalid,
  output logic [7:0]        host_rdata,
  output logic              irq,
  input  logic              irq_ack,
  output logic              rdr_req,
  input  logic              rdr_strobe,
  input  logic [CHAR_W-1:0] rdr_data,
  input  logic              rdr_eom,
  input  logic              rdr_online,
  output logic              pch_start,
  output logic [CHAR_W-1:0] pch_data,
  input  logic              pch_done,
  input  logic              pch_online
);
  host_op_e op;
  logic cmd_we, rd_op, wr_op, ss_op;
  logic dir_rd, run, slew, armed, arm_next, dir_next, dir_chg;
  logic run_start, run_stop, punch_cmd;
  logic rdr_active, char_evt, overrun, eot, pch_active, done_evt;
  logic [CHAR_W-1:0] buf_w;
  logic [HOST_W-1:0] buf_ext, status;
  logic busy_q, busy_d, irq_q, irq_d, rvalid_q, nomo, unav, new_active;
  logic [HOST_W-1:0] rdata_q;

  assign op     = host_op_e'(host_op);
  assign cmd_we = host_valid && (op == OP_CMD);
  assign rd_op  = host_valid && (op == OP_RDATA);
  assign wr_op  = host_valid && (op == OP_WDATA);
  assign ss_op  = host_valid && (op == OP_SENSE);

  ptrp_mode u_mode (
    .clk(clk), .rst(rst), .cmd_we(cmd_we),
    .cmd_dir(host_wdata[CB_DIR]), .cmd_run(host_wdata[CB_RUN]),
    .cmd_slew(host_wdata[CB_SLEW]), .cmd_arm(host_wdata[CB_ARM+1:CB_ARM]),
    .dir_rd(dir_rd), .run(run), .slew(slew), .armed(armed),
    .arm_next(arm_next), .dir_next(dir_next), .dir_chg(dir_chg),
    .run_start(run_start), .run_stop(run_stop), .punch_cmd(punch_cmd)
  );

  ptrp_reader #(.CHAR_W(CHAR_W)) u_reader (
    .clk(clk), .rst(rst), .dir_rd(dir_rd), .run(run), .slew(slew),
    .run_start(run_start), .run_stop(run_stop), .dir_chg(dir_chg),
    .punch_cmd(punch_cmd), .rd_op(rd_op), .rdr_strobe(rdr_strobe),
    .rdr_data(rdr_data), .rdr_eom(rdr_eom), .rdr_req(rdr_req),
    .rdr_active(rdr_active), .char_evt(char_evt), .overrun(overrun),
    .eot(eot), .buf_o(buf_w)
  );

  ptrp_punch #(.CHAR_W(CHAR_W)) u_punch (
    .clk(clk), .rst(rst), .wr_op(wr_op), .wdata(host_wdata[CHAR_W-1:0]),
    .pch_done(pch_done), .pch_start(pch_start), .pch_data(pch_data),
    .pch_active(pch_active), .done_evt(done_evt)
  );

  assign new_active = dir_next ? rdr_active : pch_active;

  always_comb begin
    busy_d = busy_q;
    irq_d  = irq_q && !irq_ack;
    if (char_evt) begin
      busy_d = 1'b0;
      if (arm_next) irq_d = 1'b1;
    end
    if (done_evt && !dir_rd) begin
      busy_d = 1'b0;
      if (arm_next) irq_d = 1'b1;
    end
    if (rd_op && dir_rd)  busy_d = 1'b1;
    if (wr_op && !dir_rd) busy_d = 1'b1;
    if (dir_chg) begin
      busy_d = new_active;
      if (new_active)    irq_d = 1'b0;
      else if (arm_next) irq_d = 1'b1;
    end
  end

  assign nomo = dir_rd && !run && !rdr_active;
  assign unav = (dir_rd ? !rdr_online : !pch_online) || eot;

  always_comb begin
    status          = '0;
    status[SB_OVR]  = overrun;
    status[SB_NOMO] = nomo;
    status[SB_BUSY] = busy_q;
    status[SB_EXC]  = overrun || nomo;
    status[SB_UNAV] = unav;
    buf_ext         = '0;
    buf_ext[CHAR_W-1:0] = buf_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b1;
      irq_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      busy_q   <= busy_d;
      irq_q    <= irq_d;
      rvalid_q <= rd_op || ss_op;
      if (rd_op)      rdata_q <= buf_ext;
      else if (ss_op) rdata_q <= status;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rdata_q;
  assign irq         = irq_q;

  // R11: the interrupt only rises while armed
  a_r11_irq_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> armed);
  // R11: without acknowledge or direction change the interrupt holds
  a_r11_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_ack && !dir_chg) |=> irq_q);
  // R10: punch done in read direction leaves busy alone
  a_r10_done_in_read: assert property (@(posedge clk) disable iff (rst)
    (done_evt && dir_rd && !host_valid && !rdr_strobe) |=> $stable(busy_q));
endmodule

// File: tb/ptrp_ctrl_bench.sv
module ptrp_ctrl_bench;
  import ptrp_pkg::*;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_valid = 1'b0;
  logic [1:0] host_op = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic host_rvalid;
  logic [7:0] host_rdata;
  logic irq, irq_ack = 1'b0;
  logic rdr_req, rdr_strobe = 1'b0, rdr_eom = 1'b0, rdr_online = 1'b1;
  logic [CW-1:0] rdr_data = '0;
  logic pch_start, pch_done = 1'b0, pch_online = 1'b1;
  logic [CW-1:0] pch_data;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ptrp_ctrl #(.CHAR_W(CW)) u_ptrp_ctrl (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_op(host_op),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .irq(irq), .irq_ack(irq_ack), .rdr_req(rdr_req), .rdr_strobe(rdr_strobe),
    .rdr_data(rdr_data), .rdr_eom(rdr_eom), .rdr_online(rdr_online),
    .pch_start(pch_start), .pch_data(pch_data), .pch_done(pch_done),
    .pch_online(pch_online)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rdr_req) req_cnt <= req_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hop(input host_op_e o, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_op = o; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic sense_is(input string tag, input int exp);
    hop(OP_SENSE, 8'h00);
    chk(tag, {host_rvalid, host_rdata}, {1'b1, exp[7:0]});
  endtask

  task automatic read_is(input string tag, input int exp);
    hop(OP_RDATA, 8'h00);
    chk(tag, {host_rvalid, host_rdata}, {1'b1, exp[7:0]});
  endtask

  task automatic strobe(input logic [7:0] d, input logic eom);
    @(negedge clk);
    rdr_strobe = 1'b1; rdr_data = d; rdr_eom = eom;
    @(negedge clk);
    rdr_strobe = 1'b0; rdr_eom = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); pch_done = 1'b1;
    @(negedge clk); pch_done = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    sense_is("R1 reset status", 8'h1C);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset no request", req_cnt, 0);
  endtask

  task automatic t_step();
    hop(OP_CMD, 8'h91);                     // arm, run, step, read
    settle();
    chk("R5 run start request", req_cnt, 1);
    sense_is("R2 running status", 8'h08);
    strobe(8'hA5, 1'b0);
    chk("R6 irq on char", irq, 1);
    sense_is("R6 busy clear", 8'h00);
    read_is("R8 read data", 8'hA5);
    settle();
    chk("R8 step request", req_cnt, 2);
    chk("R11 irq held", irq, 1);
    sense_is("R8 busy set", 8'h08);
    ack();
    chk("R11 irq ack", irq, 0);
  endtask

  task automatic t_overrun();
    strobe(8'h11, 1'b0);
    strobe(8'h22, 1'b0);
    sense_is("R6 overrun status", 8'h84);
    read_is("R6 last byte", 8'h22);
    sense_is("R3 overrun busy", 8'h8C);
    settle();
    chk("R8 step request 2", req_cnt, 3);
  endtask

  task automatic t_punch();
    ack();
    hop(OP_CMD, 8'h80);                     // punch direction
    chk("R4 irq on idle dir", irq, 1);
    sense_is("R4 overrun cleared", 8'h00);
    ack();
    hop(OP_WDATA, 8'h5A);
    chk("R10 start pulse", pch_start, 1);
    chk("R10 punch data", pch_data, 8'h5A);
    sense_is("R10 busy in punch", 8'h08);
    done_pulse();
    chk("R10 done irq", irq, 1);
    sense_is("R10 done busy", 8'h00);
    pch_online = 1'b0;
    sense_is("R3 punch offline", 8'h01);
    pch_online = 1'b1;
  endtask

  task automatic t_dir_busy();
    hop(OP_WDATA, 8'h77);
    hop(OP_CMD, 8'h91);                     // back to read, reader pending
    chk("R4 irq withdrawn", irq, 0);
    sense_is("R4 busy active mech", 8'h08);
    done_pulse();
    chk("R10 done in read no irq", irq, 0);
    sense_is("R10 done in read busy", 8'h08);
    hop(OP_CMD, 8'h80);
    hop(OP_CMD, 8'h91);
    settle();
    chk("R2 run kept over punch cmd", req_cnt, 3);
  endtask

  task automatic t_slew_eom();
    hop(OP_CMD, 8'h95);                     // slew
    strobe(8'h41, 1'b0);
    settle();
    chk("R7 slew request", req_cnt, 4);
    read_is("R7 slew data", 8'h41);
    settle();
    chk("R7 read no request", req_cnt, 4);
    ack();
    strobe(8'hEE, 1'b1);
    settle();
    chk("R9 no request at eom", req_cnt, 4);
    chk("R9 irq at eom", irq, 1);
    sense_is("R9 eot status", 8'h01);
    read_is("R9 buffer kept", 8'h41);
    sense_is("R9 busy after read", 8'h09);
    hop(OP_CMD, 8'h84);                     // punch clears eot
    sense_is("R12 eot cleared", 8'h00);
  endtask

  task automatic t_stop_disarm();
    hop(OP_CMD, 8'h81);                     // read, stopped
    sense_is("R5 stopped status", 8'h14);
    strobe(8'h99, 1'b0);
    settle();
    chk("R5 discard no request", req_cnt, 4);
    sense_is("R5 discard status", 8'h14);
    read_is("R5 discard buffer", 8'h41);
    ack();
    hop(OP_CMD, 8'h51);                     // disarm, run
    settle();
    chk("R5 restart request", req_cnt, 5);
    strobe(8'h66, 1'b0);
    chk("R11 disarmed no irq", irq, 0);
    sense_is("R6 disarmed status", 8'h00);
    read_is("R6 disarmed data", 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_step();
    t_overrun();
    t_punch();
    t_dir_busy();
    t_slew_eom();
    t_stop_disarm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule